// File: doc/BRIEF.md
# Four-Channel DMA Burst Arbiter

This block decides which requester owns a shared data path between two buses for the next burst. Four DMA channels and one programmed-I/O requester compete. A channel raises its request when its staging buffer is ready to be filled or drained. The PIO requester always beats every DMA channel. Among the DMA channels, a mode input selects either a fixed ladder, where the lowest channel number wins, or a rotating order, where the channel served last drops to the bottom.

A grant covers one burst of up to 32 bytes. It is registered, one-hot and held until the data path signals that the burst is finished. The arbiter then spends one cycle with no grant and decides again. A synchronous software reset ends any burst at once and returns all arbitration state to its initial value.

Top module: `dma_burst_arbiter`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it is released, `grant` is all zeros and `grant_valid` is low.
- R2: When no grant is held and `pio_req` is high, the next grant is the PIO bit (`grant[4]`), whatever `dma_req` and `rr_mode` are.
- R3: With `rr_mode` = 0, the granted DMA channel is the lowest-numbered requesting channel.
- R4: With `rr_mode` = 1, the search starts at the channel after the last DMA channel granted, wrapping from 3 to 0. After reset the search starts at channel 0. The pointer tracks DMA grants in both modes.
- R5: While a grant is held and `burst_done` is low, `grant` does not change, whatever the requests do.
- R6: A `burst_done` sampled high while a grant is held clears `grant` at that edge. The next decision uses the requests sampled on the following edge.
- R7: With no request pending, `grant_valid` stays low and `grant` stays all zeros.
- R8: `rr_mode` is sampled only at a decision edge. A change during a burst neither alters the held grant nor the burst's end.
- R9: `sw_reset` sampled high clears the grant at that edge and returns the rotating search start to channel 0.
- R10: `grant` has at most one bit set. Bit i (0 to 3) is DMA channel i and bit 4 is PIO. `grant_valid` is high exactly when a bit is set.
- R11: A PIO grant leaves the rotating search start where it was.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| sw_reset | input | 1 | Synchronous software reset, active high |
| dma_req | input | 4 | Per-channel DMA burst requests |
| pio_req | input | 1 | Programmed-I/O request, highest priority |
| rr_mode | input | 1 | 0 = fixed priority, 1 = rotating priority |
| burst_done | input | 1 | Strobe: the granted burst has finished |
| grant | output | 5 | One-hot owner: bits 3..0 DMA channels, bit 4 PIO |
| grant_valid | output | 1 | A grant is held |

## Verification
Every result comes out of a single register, so each one is due exactly one rising edge after the inputs that cause it:
- a new grant follows the edge that samples the requests;
- a cleared grant follows the edge that samples `burst_done` or `sw_reset`.

The driver changes inputs on the falling edge and queues the grant due after the next rising edge. The monitor samples 2 ns after that rising edge. Each queued item therefore lines up with exactly one register update.

Burst sequences are run in both modes so that the rotating pointer's history, including wrap-around, PIO grants and the software reset, is visible in later decisions.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;

   typedef enum logic {
      ARB_FIXED  = 1'b0,
      ARB_ROTATE = 1'b1
   } arb_mode_e;

   // width of an index able to name n entries
   function automatic int unsigned idx_w(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/dma_arb_fixed.sv
module dma_arb_fixed #(
   parameter int unsigned NCH = 4
) (
   input  logic [NCH-1:0] req,
   output logic [NCH-1:0] pick
);

   generate
      if (NCH < 1) begin : g_bad
         $error("dma_arb_fixed: NCH must be at least 1");
      end
      for (genvar i = 0; i < NCH; i++) begin : g_lad
         if (i == 0) begin : g_top
            assign pick[0] = req[0];
         end else begin : g_rest
            assign pick[i] = req[i] & ~(|req[i-1:0]);
         end
      end
   endgenerate

endmodule

// File: rtl/dma_arb_rotate.sv
module dma_arb_rotate #(
   parameter int unsigned NCH = 4,
   parameter int unsigned IW  = 2
) (
   input  logic [NCH-1:0] req,
   input  logic [IW-1:0]  base,
   output logic [NCH-1:0] pick
);

   generate
      if ((1 << IW) < NCH) begin : g_bad
         $error("dma_arb_rotate: IW too narrow for NCH");
      end
   endgenerate

   always_comb begin
      logic          found;
      logic [IW-1:0] idx;
      pick  = '0;
      found = 1'b0;
      for (int k = 0; k < NCH; k++) begin
         idx = IW'((int'(base) + k) % NCH);
         if (!found && req[idx]) begin
            pick[idx] = 1'b1;
            found     = 1'b1;
         end
      end
   end

endmodule

// File: rtl/dma_arb_ptr.sv
module dma_arb_ptr #(
   parameter int unsigned NCH = 4,
   parameter int unsigned IW  = 2
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           clr,
   input  logic           load,
   input  logic [NCH-1:0] served,
   output logic [IW-1:0]  base
);

   logic [IW-1:0] base_nxt;

   // next search start: the channel after the one just served
   always_comb begin
      base_nxt = base;
      for (int i = 0; i < NCH; i++) begin
         if (served[i]) begin
            base_nxt = (i == NCH - 1) ? '0 : IW'(i + 1);
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base <= '0;
      end else if (clr) begin
         base <= '0;
      end else if (load) begin
         base <= base_nxt;
      end
   end

   AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (load && !clr && served[NCH-1]) |=> (base == '0)) else $error("wrap failed"); // R4

endmodule

// File: rtl/dma_burst_arbiter.sv
module dma_burst_arbiter #(
   parameter int unsigned NCH            = 4,
   parameter bit          SUPPORT_ROTATE = 1'b1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           sw_reset,
   input  logic [NCH-1:0] dma_req,
   input  logic           pio_req,
   input  logic           rr_mode,
   input  logic           burst_done,
   output logic [NCH:0]   grant,
   output logic           grant_valid
);

   import dma_arb_pkg::*;

   localparam int unsigned IW = idx_w(NCH);
   localparam int unsigned GW = NCH + 1;

   generate
      if (NCH < 2) begin : g_bad
         $error("dma_burst_arbiter: need at least two DMA channels");
      end
   endgenerate

   logic [GW-1:0]  grant_q;
   logic [NCH-1:0] fix_pick;
   logic [NCH-1:0] rot_pick;
   logic [NCH-1:0] dma_pick;
   logic [GW-1:0]  next_grant;
   logic [IW-1:0]  rr_base;
   logic           held;
   logic           decide;
   arb_mode_e      mode;

   assign mode = arb_mode_e'(rr_mode);
   assign held = |grant_q;

   dma_arb_fixed #(.NCH(NCH)) u_fixed (
      .req  (dma_req),
      .pick (fix_pick)
   );

   generate
      if (SUPPORT_ROTATE) begin : g_rot
         dma_arb_rotate #(.NCH(NCH), .IW(IW)) u_rot (
            .req  (dma_req),
            .base (rr_base),
            .pick (rot_pick)
         );
      end else begin : g_norot
         assign rot_pick = fix_pick;
      end
   endgenerate

   assign dma_pick   = (mode == ARB_ROTATE) ? rot_pick : fix_pick;
   assign next_grant = pio_req ? {1'b1, {NCH{1'b0}}} : {1'b0, dma_pick};
   assign decide     = !held && !sw_reset;

   dma_arb_ptr #(.NCH(NCH), .IW(IW)) u_ptr (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (sw_reset),
      .load   (decide && !pio_req && (|dma_req)),
      .served (dma_pick),
      .base   (rr_base)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         grant_q <= '0;
      end else if (sw_reset) begin
         grant_q <= '0;
      end else if (held) begin
         if (burst_done) begin
            grant_q <= '0;
         end
      end else begin
         grant_q <= next_grant;
      end
   end

   assign grant       = grant_q;
   assign grant_valid = held;

   AST_ONE_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant)) else $error("grant not one-hot"); // R10

   AST_PIO_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      (!grant_valid && pio_req && !sw_reset) |=> grant[NCH]) else $error("PIO lost"); // R2

   AST_FIXED_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (!grant_valid && !pio_req && !rr_mode && dma_req[0] && !sw_reset) |=> grant[0])
      else $error("fixed order broken"); // R3

   AST_HOLD_BURST: assert property (@(posedge clk) disable iff (!rst_n)
      (grant_valid && !burst_done && !sw_reset) |=> $stable(grant))
      else $error("grant moved mid-burst"); // R5

   AST_DROP_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      (grant_valid && burst_done) |=> !grant_valid) else $error("grant kept after done"); // R6

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (!grant_valid && !pio_req && !(|dma_req)) |=> !grant_valid)
      else $error("grant without request"); // R7

   AST_SW_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      sw_reset |=> !grant_valid) else $error("software reset ignored"); // R9

endmodule

// File: tb/dma_burst_arbiter_test.sv
`timescale 1ns/1ps
module dma_burst_arbiter_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sw_reset = 1'b0;
   logic [3:0] dma_req = '0;
   logic       pio_req = 1'b0;
   logic       rr_mode = 1'b0;
   logic       burst_done = 1'b0;
   logic [4:0] grant;
   logic       grant_valid;

   int checks = 0;
   int errors = 0;
   logic [4:0] exp_q[$];
   string      tag_q[$];
   logic [4:0] mon_exp;
   string      mon_tag;

   always #4 clk = ~clk;

   dma_burst_arbiter uut (
      .clk(clk), .rst_n(rst_n), .sw_reset(sw_reset), .dma_req(dma_req),
      .pio_req(pio_req), .rr_mode(rr_mode), .burst_done(burst_done),
      .grant(grant), .grant_valid(grant_valid)
   );

   // driver: one cycle of stimulus and the grant due after the next rising edge
   task automatic cyc(input logic [3:0] rq, input logic p, input logic m,
                      input logic d, input logic s, input logic [4:0] e,
                      input string tag);
      @(negedge clk);
      dma_req = rq; pio_req = p; rr_mode = m; burst_done = d; sw_reset = s;
      exp_q.push_back(e);
      tag_q.push_back(tag);
   endtask

   // monitor: compare shortly after each rising edge
   always @(posedge clk) begin
      #2;
      if (exp_q.size() > 0) begin
         mon_exp = exp_q.pop_front();
         mon_tag = tag_q.pop_front();
         checks++;
         if (grant !== mon_exp) begin
            errors++;
            $display("FAIL %s grant actual %b expected %b", mon_tag, grant, mon_exp);
         end
         checks++;
         if (grant_valid !== (mon_exp != 5'b0)) begin
            errors++;
            $display("FAIL R10 grant_valid actual %b expected %b", grant_valid, mon_exp != 5'b0);
         end
      end
   end

   initial begin
      #(200000 * 8);
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      dma_req = 4'b1111; pio_req = 1'b1;
      repeat (3) @(negedge clk);
      checks++;
      if (grant !== 5'b0 || grant_valid !== 1'b0) begin
         errors++;
         $display("FAIL R1 reset actual %b/%b expected 00000/0", grant, grant_valid);
      end
      dma_req = '0; pio_req = 1'b0;
      rst_n = 1'b1;
      cyc(4'b0000, 0, 0, 0, 0, 5'b00000, "R1");
      cyc(4'b0000, 0, 0, 0, 0, 5'b00000, "R7");
      // fixed priority
      cyc(4'b1010, 0, 0, 0, 0, 5'b00010, "R3");
      cyc(4'b0001, 0, 0, 0, 0, 5'b00010, "R5");
      cyc(4'b0001, 0, 1, 0, 0, 5'b00010, "R8");
      cyc(4'b0001, 0, 0, 1, 0, 5'b00000, "R6");
      cyc(4'b1000, 0, 0, 0, 0, 5'b01000, "R3");
      cyc(4'b0000, 0, 0, 1, 0, 5'b00000, "R6");
      cyc(4'b1111, 1, 0, 0, 0, 5'b10000, "R2");
      cyc(4'b1111, 0, 0, 1, 0, 5'b00000, "R6");
      cyc(4'b1111, 0, 0, 0, 0, 5'b00001, "R3");
      // pointer now 1; mode switched on the drop cycle is used at the decision
      cyc(4'b1111, 0, 1, 1, 0, 5'b00000, "R8");
      cyc(4'b1111, 0, 1, 0, 0, 5'b00010, "R4");
      cyc(4'b1111, 0, 1, 1, 0, 5'b00000, "R6");
      cyc(4'b1111, 0, 1, 0, 0, 5'b00100, "R4");
      cyc(4'b1111, 0, 1, 1, 0, 5'b00000, "R6");
      cyc(4'b1001, 0, 1, 0, 0, 5'b01000, "R4");
      cyc(4'b1001, 0, 1, 1, 0, 5'b00000, "R6");
      cyc(4'b1001, 0, 1, 0, 0, 5'b00001, "R4");
      cyc(4'b1001, 0, 1, 1, 0, 5'b00000, "R6");
      cyc(4'b1111, 1, 1, 0, 0, 5'b10000, "R2");
      cyc(4'b1111, 0, 1, 1, 0, 5'b00000, "R6");
      cyc(4'b0101, 0, 1, 0, 0, 5'b00100, "R11");
      cyc(4'b1111, 0, 1, 0, 1, 5'b00000, "R9");
      cyc(4'b1111, 0, 1, 0, 0, 5'b00001, "R9");
      cyc(4'b0000, 0, 1, 1, 0, 5'b00000, "R6");
      cyc(4'b0000, 0, 1, 0, 0, 5'b00000, "R7");
      cyc(4'b0000, 1, 1, 0, 0, 5'b10000, "R2");
      @(negedge clk);
      dma_req = '0; pio_req = 1'b0; burst_done = 1'b0;
      @(posedge clk);
      #3;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule